// File: doc/BRIEF.md
# Configuration Transaction Controller

This block runs remote configuration transactions through three register slots: a data word, a control word and a status word. Software writes a control word with its launch bit set. The controller splits the word into its route fields (controller index, function, site, stack position, device) and checks whether the route names a supported target. It then runs the read or the write against a local table of oscillator frequencies and voltage readings. Completion and error land in the status word on the clock edge that accepts the launch.

The table holds six motherboard oscillators, a parameterised number of daughterboard oscillators and a parameterised number of daughterboard voltage readings. It also holds one fixed motherboard supply reading. A write to the power-off or restart function produces a single-cycle request pulse on a dedicated pin. Video-routing and display-mode writes are accepted and have no further effect.

The register port is a plain single-cycle write strobe with a shared byte address. Read data is combinational from that address. The port has no back-pressure and takes one access per cycle. There is no data stream, so the block has no valid/ready interface.

Top module: `cfgx_ctrl`

## Requirements
- R1: The control word sits at byte address 0xA4. Writes store every bit except bit 31 (launch) and bits 19:18, which always read as zero. A control write with bit 31 clear starts nothing and leaves the status word unchanged.
- R2: A control write with bit 31 set launches a transaction. From the next cycle, status bit 0 (done) is 1 and status bit 1 (error) shows whether that transaction failed. The launch replaces any earlier status value.
- R3: The control word fields are: bit 30 write(1)/read(0), bits 29:26 controller index, bits 25:20 function, bits 17:16 site, bits 15:12 stack position, bits 11:0 device. A launch with a nonzero controller index, a nonzero stack position, or site 2 or 3 fails.
- R4: Function 1 (oscillator) on site 0 is valid for devices 0 to 5. Their reset values are 50000000, 23750000, and 24000000 for devices 2 to 5. Device 6 and above fail.
- R5: An oscillator write stores the data word (address 0xA0) into the addressed entry. A later read of that entry returns it, on site 0 and on site 1 alike.
- R6: On site 1, oscillator device i is valid for i below DB_OSC_N. It resets to DB_OSC_BASE + i*DB_OSC_STEP; the defaults are 2, 60000000 and 1000000.
- R7: A function 2 (voltage) read returns 3300000 for site 0 device 0. For site 1 device i below DB_VOLT_N it returns DB_VOLT_BASE + i*DB_VOLT_STEP; the defaults are 2, 1000000 and 100000. Any voltage write fails.
- R8: A write launch with function 8 on site 0 device 0 raises shutdown_req for exactly one cycle, starting the cycle after the launch. Function 9 does the same on reboot_req. Any other device fails and raises no pulse.
- R9: Writes with function 7 or 11 on site 0 device 0 succeed with no other effect. Reads of those functions, and any other function code, fail.
- R10: A write to the status word (address 0xA8) stores only bits 1:0 of the written value.
- R11: A successful read puts its result in the data word. A failed read or any write launch leaves the data word unchanged.
- R12: The data word reads back what was last written to it. Any address other than 0xA0, 0xA4 and 0xA8 reads as zero, and writes to it change nothing.
- R13: After reset the data, control and status words all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| shutdown_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
Read data is combinational from the address, so a register value can be read back a moment after the address changes. All other results come from the single clock edge that takes the launching control write. From that edge onward the status, the data word, the table entry and any request pulse are in place, and the pulse is gone one edge later. The bench drives each write on a falling edge and samples on the next falling edge, so every check sits half a cycle after its result is due. It then checks the pulse again one full cycle later to confirm the pulse has dropped.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int WORD_W   = 32;
  localparam int DEV_W    = 12;
  localparam int MB_OSC_N = 6;

  localparam logic [7:0] ADDR_DATA = 8'hA0;
  localparam logic [7:0] ADDR_CTRL = 8'hA4;
  localparam logic [7:0] ADDR_STAT = 8'hA8;

  localparam logic [5:0] FN_OSC  = 6'd1;
  localparam logic [5:0] FN_VOLT = 6'd2;
  localparam logic [5:0] FN_VMUX = 6'd7;
  localparam logic [5:0] FN_OFF  = 6'd8;
  localparam logic [5:0] FN_BOOT = 6'd9;
  localparam logic [5:0] FN_DISP = 6'd11;

  localparam logic [WORD_W-1:0] MB_SUPPLY_UV = 32'd3300000;
  localparam logic [WORD_W-1:0] CTRL_KEEP    = 32'h7FF3_FFFF;

  typedef struct packed {
    logic             go;
    logic             wr;
    logic [3:0]       ctl_idx;
    logic [5:0]       fn;
    logic [1:0]       unused;
    logic [1:0]       site;
    logic [3:0]       pos;
    logic [DEV_W-1:0] dev;
  } ctrl_word_t;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_OSC_MB,
    TGT_OSC_DB,
    TGT_VOLT_MB,
    TGT_VOLT_DB,
    TGT_VMUX,
    TGT_DISP,
    TGT_OFF,
    TGT_BOOT
  } tgt_e;

  function automatic logic [WORD_W-1:0] mb_osc_reset(input int i);
    if (i == 0)      return 32'd50000000;
    else if (i == 1) return 32'd23750000;
    else             return 32'd24000000;
  endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N  = 2,
  parameter int DB_VOLT_N = 2
) (
  input  ctrl_word_t word,
  output tgt_e       tgt
);

  localparam logic [DEV_W-1:0] MB_OSC_LIM  = DEV_W'(MB_OSC_N);
  localparam logic [DEV_W-1:0] DB_OSC_LIM  = DEV_W'(DB_OSC_N);
  localparam logic [DEV_W-1:0] DB_VOLT_LIM = DEV_W'(DB_VOLT_N);

  logic route_ok, on_mb, on_db, dev0;

  always_comb begin
    route_ok = (word.ctl_idx == 4'd0) && (word.pos == 4'd0) && !word.site[1];
    on_mb    = (word.site == 2'd0);
    on_db    = (word.site == 2'd1);
    dev0     = (word.dev == '0);
    tgt      = TGT_NONE;
    if (route_ok) begin
      unique case (word.fn)
        FN_OSC: begin
          if (on_mb && word.dev < MB_OSC_LIM)      tgt = TGT_OSC_MB;
          else if (on_db && word.dev < DB_OSC_LIM) tgt = TGT_OSC_DB;
        end
        FN_VOLT: begin
          if (!word.wr) begin
            if (on_mb && dev0)                          tgt = TGT_VOLT_MB;
            else if (on_db && word.dev < DB_VOLT_LIM)   tgt = TGT_VOLT_DB;
          end
        end
        FN_VMUX: if (word.wr && on_mb && dev0) tgt = TGT_VMUX;
        FN_DISP: if (word.wr && on_mb && dev0) tgt = TGT_DISP;
        FN_OFF:  if (word.wr && on_mb && dev0) tgt = TGT_OFF;
        FN_BOOT: if (word.wr && on_mb && dev0) tgt = TGT_BOOT;
        default: tgt = TGT_NONE;
      endcase
    end
  end

  // R3: a resolved target never carries a foreign controller index or stack position
  always_comb begin
    a_r3_route_guard: assert (tgt == TGT_NONE ||
                              (word.ctl_idx == 4'd0 && word.pos == 4'd0 && word.site[1] == 1'b0));
  end

endmodule

// File: rtl/cfgx_target_table.sv
module cfgx_target_table
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N     = 2,
  parameter int DB_VOLT_N    = 2,
  parameter int DB_OSC_BASE  = 60000000,
  parameter int DB_OSC_STEP  = 1000000,
  parameter int DB_VOLT_BASE = 1000000,
  parameter int DB_VOLT_STEP = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              tgt,
  input  logic [DEV_W-1:0]  dev,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_val,
  output logic [WORD_W-1:0] rd_val
);

  logic [WORD_W-1:0] mb_osc [MB_OSC_N];
  logic [WORD_W-1:0] db_osc [DB_OSC_N];
  logic [WORD_W-1:0] db_volt;

  for (genvar i = 0; i < MB_OSC_N; i++) begin : g_mb_osc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mb_osc[i] <= mb_osc_reset(i);
      else if (wr_en && tgt == TGT_OSC_MB && dev == DEV_W'(i))
        mb_osc[i] <= wr_val;
    end
  end

  for (genvar i = 0; i < DB_OSC_N; i++) begin : g_db_osc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        db_osc[i] <= WORD_W'(DB_OSC_BASE + i * DB_OSC_STEP);
      else if (wr_en && tgt == TGT_OSC_DB && dev == DEV_W'(i))
        db_osc[i] <= wr_val;
    end
  end

  always_comb begin
    db_volt = WORD_W'(DB_VOLT_BASE) + WORD_W'(DB_VOLT_STEP) * {{(WORD_W-DEV_W){1'b0}}, dev};
  end

  always_comb begin
    rd_val = '0;
    unique case (tgt)
      TGT_OSC_MB: begin
        for (int i = 0; i < MB_OSC_N; i++)
          if (dev == DEV_W'(i)) rd_val = mb_osc[i];
      end
      TGT_OSC_DB: begin
        for (int i = 0; i < DB_OSC_N; i++)
          if (dev == DEV_W'(i)) rd_val = db_osc[i];
      end
      TGT_VOLT_MB: rd_val = MB_SUPPLY_UV;
      TGT_VOLT_DB: rd_val = db_volt;
      default:     rd_val = '0;
    endcase
  end

  // R7: the fixed motherboard supply reading is offered whenever it is the target
  a_r7_supply_value: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_VOLT_MB) |-> (rd_val == MB_SUPPLY_UV));

endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N     = 2,
  parameter int DB_VOLT_N    = 2,
  parameter int DB_OSC_BASE  = 60000000,
  parameter int DB_OSC_STEP  = 1000000,
  parameter int DB_VOLT_BASE = 1000000,
  parameter int DB_VOLT_STEP = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        shutdown_req,
  output logic        reboot_req
);

  logic [WORD_W-1:0] data_q, ctrl_q;
  logic [1:0]        stat_q;
  logic              off_q, boot_q;

  ctrl_word_t        cmd;
  tgt_e              tgt;
  logic              launch, fail, is_wr;
  logic [WORD_W-1:0] tbl_rd;

  always_comb begin
    cmd    = ctrl_word_t'(bus_wdata);
    launch = bus_we && (bus_addr == ADDR_CTRL) && cmd.go;
    is_wr  = cmd.wr;
    fail   = (tgt == TGT_NONE);
  end

  cfgx_decode #(
    .DB_OSC_N  (DB_OSC_N),
    .DB_VOLT_N (DB_VOLT_N)
  ) u_decode (
    .word (cmd),
    .tgt  (tgt)
  );

  cfgx_target_table #(
    .DB_OSC_N     (DB_OSC_N),
    .DB_VOLT_N    (DB_VOLT_N),
    .DB_OSC_BASE  (DB_OSC_BASE),
    .DB_OSC_STEP  (DB_OSC_STEP),
    .DB_VOLT_BASE (DB_VOLT_BASE),
    .DB_VOLT_STEP (DB_VOLT_STEP)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgt    (tgt),
    .dev    (cmd.dev),
    .wr_en  (launch && is_wr),
    .wr_val (data_q),
    .rd_val (tbl_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      off_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      off_q  <= launch && is_wr && (tgt == TGT_OFF);
      boot_q <= launch && is_wr && (tgt == TGT_BOOT);
      if (launch && !is_wr && !fail)
        data_q <= tbl_rd;
      else if (bus_we && bus_addr == ADDR_DATA)
        data_q <= bus_wdata;
      if (bus_we && bus_addr == ADDR_CTRL)
        ctrl_q <= bus_wdata & CTRL_KEEP;
      if (launch)
        stat_q <= {fail, 1'b1};
      else if (bus_we && bus_addr == ADDR_STAT)
        stat_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = data_q;
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_STAT: bus_rdata = {30'd0, stat_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign shutdown_req = off_q;
  assign reboot_req   = boot_q;

  // R1: launch bit and bits 19:18 are never visible on a control read
  a_r1_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CTRL) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

  // R2: any launch reports done on the following cycle
  a_r2_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stat_q[0]);

  // R3: a foreign controller index always ends in error
  a_r3_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cmd.ctl_idx != 4'd0) |=> stat_q[1]);

  // R8: request pulses last one cycle and never overlap
  a_r8_off_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  a_r8_boot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);
  a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown_req, reboot_req}));

  // R11: a write launch never touches the data word
  a_r11_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && is_wr) |=> $stable(data_q));

endmodule

// File: tb/sim_cfgx_ctrl.sv
module sim_cfgx_ctrl;

  localparam logic [7:0] A_DATA = 8'hA0;
  localparam logic [7:0] A_CTRL = 8'hA4;
  localparam logic [7:0] A_STAT = 8'hA8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        shutdown_req, reboot_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfgx_ctrl u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .shutdown_req (shutdown_req),
    .reboot_req   (reboot_req)
  );

  localparam int NV = 24;
  // launch word, preloaded data word, expected status, expected data word
  localparam logic [31:0] V_CTRL [NV] = '{
    32'h8010_0000, 32'h8010_0001, 32'h8010_0002, 32'h8010_0005, // R4
    32'h8010_0006,                                              // R4 out of range
    32'h8011_0001, 32'h8011_0002,                               // R6
    32'h8020_0000, 32'h8020_0001, 32'h8021_0001,                // R7
    32'h8410_0000, 32'h8010_1000, 32'h8012_0000, 32'h8013_0000, // R3
    32'hC010_0003, 32'h8010_0003, 32'hC011_0000, 32'h8011_0000, // R5 R11
    32'hC020_0000,                                              // R7 write fails
    32'hC070_0000, 32'h8070_0000, 32'hC0B0_0000,                // R9
    32'hC080_0001, 32'hC0A0_0000                                // R8 R9
  };
  localparam logic [31:0] V_PRE [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h1234,
    32'h0, 32'h1234,
    32'h0, 32'h55, 32'h0,
    32'h7, 32'h7, 32'h7, 32'h7,
    32'h0BEBC200, 32'h0, 32'h00ABCDEF, 32'h0,
    32'h99,
    32'h42, 32'h42, 32'h42,
    32'h42, 32'h42
  };
  localparam logic [1:0] V_STAT [NV] = '{
    2'd1, 2'd1, 2'd1, 2'd1, 2'd3,
    2'd1, 2'd3,
    2'd1, 2'd3, 2'd1,
    2'd3, 2'd3, 2'd3, 2'd3,
    2'd1, 2'd1, 2'd1, 2'd1,
    2'd3,
    2'd1, 2'd3, 2'd1,
    2'd3, 2'd3
  };
  localparam logic [31:0] V_DATA [NV] = '{
    32'd50000000, 32'd23750000, 32'd24000000, 32'd24000000, 32'h1234,
    32'd61000000, 32'h1234,
    32'd3300000, 32'h55, 32'd1100000,
    32'h7, 32'h7, 32'h7, 32'h7,
    32'h0BEBC200, 32'h0BEBC200, 32'h00ABCDEF, 32'h00ABCDEF,
    32'h99,
    32'h42, 32'h42, 32'h42,
    32'h42, 32'h42
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset values
    rd(A_DATA, v); chk("R13 data after reset", v, 32'h0);
    rd(A_CTRL, v); chk("R13 ctrl after reset", v, 32'h0);
    rd(A_STAT, v); chk("R13 status after reset", v, 32'h0);

    // vector walk
    for (int k = 0; k < NV; k++) begin
      wr(A_STAT, 32'h0);
      wr(A_DATA, V_PRE[k]);
      wr(A_CTRL, V_CTRL[k]);
      chk($sformatf("vector %0d shutdown_req R8", k), {31'd0, shutdown_req}, 32'h0);
      chk($sformatf("vector %0d reboot_req R8", k), {31'd0, reboot_req}, 32'h0);
      rd(A_STAT, v); chk($sformatf("vector %0d status R2", k), v, {30'd0, V_STAT[k]});
      rd(A_DATA, v); chk($sformatf("vector %0d data R11", k), v, V_DATA[k]);
    end

    // R1 masking and no launch without bit 31
    wr(A_STAT, 32'h2);
    wr(A_CTRL, 32'h400C_0005);
    rd(A_CTRL, v); chk("R1 ctrl readback", v, 32'h4000_0005);
    rd(A_STAT, v); chk("R1 status untouched", v, 32'h2);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R1 ctrl all ones", v, 32'h7FF3_FFFF);
    rd(A_STAT, v); chk("R3 all-ones launch fails", v, 32'h3);

    // R2 successful launch replaces earlier error
    wr(A_CTRL, 32'h8010_0002);
    rd(A_STAT, v); chk("R2 error replaced", v, 32'h1);

    // R10 status write keeps bits 1:0
    wr(A_STAT, 32'hFFFF_FFFE);
    rd(A_STAT, v); chk("R10 status masked", v, 32'h2);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R10 status clear", v, 32'h0);

    // R12 data word and unmapped space
    wr(A_DATA, 32'hDEAD_BEEF);
    rd(A_DATA, v); chk("R12 data readback", v, 32'hDEAD_BEEF);
    wr(8'h00, 32'h1111_1111);
    rd(8'h00, v); chk("R12 unmapped reads zero", v, 32'h0);
    rd(A_DATA, v); chk("R12 unmapped write ignored", v, 32'hDEAD_BEEF);

    // R8 shutdown pulse
    wr(A_CTRL, 32'hC080_0000);
    chk("R8 shutdown high", {31'd0, shutdown_req}, 32'h1);
    chk("R8 no reboot", {31'd0, reboot_req}, 32'h0);
    rd(A_STAT, v); chk("R8 shutdown status", v, 32'h1);
    @(negedge clk);
    chk("R8 shutdown dropped", {31'd0, shutdown_req}, 32'h0);

    // R8 reboot pulse
    wr(A_CTRL, 32'hC090_0000);
    chk("R8 reboot high", {31'd0, reboot_req}, 32'h1);
    chk("R8 no shutdown", {31'd0, shutdown_req}, 32'h0);
    @(negedge clk);
    chk("R8 reboot dropped", {31'd0, reboot_req}, 32'h0);

    // R5 write then read device 5, data word supplies value
    wr(A_DATA, 32'h0000_0ABC);
    wr(A_CTRL, 32'hC010_0005);
    wr(A_DATA, 32'h0);
    wr(A_CTRL, 32'h8010_0005);
    rd(A_DATA, v); chk("R5 device 5 rewritten", v, 32'h0000_0ABC);
    wr(A_CTRL, 32'h8010_0004);
    rd(A_DATA, v); chk("R4 neighbour untouched", v, 32'd24000000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule